// File: doc/BRIEF.md
# Bidirectional Shifter with Signed Shift Amount

This block is a purely combinational shifter. It moves an operand left or right by a shift amount, and the amount may be signed. When a signed amount is negative, the shift goes the other way: a left request by -n moves the operand right by n, and a right request by -n moves it left by n.

The result port is wide enough that no significant bit is ever lost. With an unsigned amount, its width is set by the longest possible left shift. With a signed amount, it is set by the reversed left shift that the most negative amount produces on a right request. The result takes the signedness of the operand. A signed operand fills with its sign bit on right shifts and is sign-extended to the full result width. An unsigned operand uses zeros for both.

The block is meant to sit inside datapaths that generate shift counts arithmetically and may produce a negative count. It needs no clock or reset, and its output follows its inputs in the same cycle.

Top module: `bidir_shifter`

## Requirements
- R1: With `dir_i` = 0 (left) and a non-negative amount n, `res_o` equals the operand, extended to the result width, times 2^n. The n lowest result bits are zero.
- R2: With `dir_i` = 1 (right) and a non-negative amount n, `res_o` equals the operand shifted right by n. An unsigned operand fills with zeros, so every result bit at or above position OP_W is zero. A signed operand fills with its sign bit.
- R3: With `dir_i` = 0 and a negative amount -n (possible only when AMT_SIGNED = 1, two's complement), `res_o` equals a right shift of the operand by n.
- R4: With `dir_i` = 1 and a negative amount -n, `res_o` equals a left shift of the operand by n. The n lowest result bits are zero.
- R5: The result width is OP_W + 2^AMT_W - 1 when AMT_SIGNED = 0, and OP_W + 2^(AMT_W-1) when AMT_SIGNED = 1.
- R6: When OP_SIGNED = 1, the operand is read as two's complement and the result is sign-extended to the full width, so the result's top bit always equals the operand's top bit. When OP_SIGNED = 0, the operand is read as unsigned and all extension bits are zero.
- R7: An amount of zero returns the operand, extended to the result width, unchanged, whichever direction `dir_i` selects.
- R8: For an unsigned 4-bit operand 1001 with a signed 3-bit amount, the results are:
  - left by 0 gives 1001
  - left by 3 gives 1001000
  - left by -2 gives 10
  - right by 2 gives 10
  - right by -2 gives 100100
- R9: The largest magnitudes keep every bit:
  - the most negative signed amount -2^(AMT_W-1) on a right request produces a left shift by 2^(AMT_W-1);
  - the largest unsigned amount 2^AMT_W - 1 on a left request places the operand's top bit in the result's top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | OP_W | Operand to shift |
| amt_i | input | AMT_W | Shift amount, two's complement when AMT_SIGNED = 1 |
| dir_i | input | 1 | Requested direction: 0 = left, 1 = right |
| res_o | output | RES_W | Shifted result, width per R5 |

## Verification
The bench builds three instances with a 3-bit amount:
- An unsigned 4-bit operand with a signed amount. This reproduces the worked example and the direction reversal.
- An unsigned 4-bit operand with an unsigned amount. This reaches the full 2^AMT_W - 1 left shift into an 11-bit result.
- A signed 5-bit operand with a signed amount. This exercises sign fill and sign extension.

Each instance is swept over every operand, every amount and both directions, so every magnitude stage of the shifter is used alone and in combination. The most negative amount and the all-ones unsigned amount both fall inside these sweeps.

// File: rtl/bidir_shift_pkg.sv
package bidir_shift_pkg;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    // Result width: the larger of the left and right width rules.
    function automatic int unsigned res_width(int unsigned op_w, int unsigned amt_w, bit amt_signed);
        int unsigned w;
        if (amt_signed)
            w = op_w + (32'd1 << (amt_w - 1));
        else
            w = op_w + (32'd1 << amt_w) - 1;
        return w;
    endfunction

endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode #(
    parameter int AMT_W      = 3,
    parameter bit AMT_SIGNED = 1'b1
) (
    input  logic [AMT_W-1:0] amt_i,
    input  logic             dir_i,
    output logic [AMT_W-1:0] mag_o,
    output logic             right_o
);
    import bidir_shift_pkg::*;

    typedef struct packed {
        logic [AMT_W-1:0] mag;
        logic             right;
    } dec_t;

    dec_t dec_d;
    logic neg_d;

    always_comb begin
        neg_d       = AMT_SIGNED && amt_i[AMT_W-1];
        // Magnitude of -2^(AMT_W-1) fits AMT_W unsigned bits.
        dec_d.mag   = neg_d ? (AMT_W'(0) - amt_i) : amt_i;
        dec_d.right = (shift_dir_e'(dir_i) == SHIFT_RIGHT) ^ neg_d;
    end

    assign mag_o   = dec_d.mag;
    assign right_o = dec_d.right;

endmodule

// File: rtl/shf_extend.sv
module shf_extend #(
    parameter int OP_W      = 4,
    parameter int RES_W     = 8,
    parameter bit OP_SIGNED = 1'b0
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [RES_W-1:0] ext_o,
    output logic             fill_o
);
    localparam int EXT_W = RES_W - OP_W;

    logic fill_d;

    always_comb begin
        fill_d = OP_SIGNED && op_i[OP_W-1];
        ext_o  = {{EXT_W{fill_d}}, op_i};
    end

    assign fill_o = fill_d;

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int RES_W = 8,
    parameter int MAG_W = 3
) (
    input  logic [RES_W-1:0] data_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             right_i,
    input  logic             fill_i,
    output logic [RES_W-1:0] data_o
);
    logic [RES_W-1:0] stage_d [MAG_W+1];

    assign stage_d[0] = data_i;

    for (genvar k = 0; k < MAG_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [RES_W-1:0] lft_d;
        logic [RES_W-1:0] rgt_d;
        always_comb begin
            lft_d = {stage_d[k][RES_W-1-STEP:0], {STEP{1'b0}}};
            rgt_d = {{STEP{fill_i}}, stage_d[k][RES_W-1:STEP]};
            if (mag_i[k])
                stage_d[k+1] = right_i ? rgt_d : lft_d;
            else
                stage_d[k+1] = stage_d[k];
        end
    end

    assign data_o = stage_d[MAG_W];

endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter #(
    parameter int OP_W       = 8,
    parameter int AMT_W      = 3,
    parameter bit OP_SIGNED  = 1'b0,
    parameter bit AMT_SIGNED = 1'b1,
    localparam int RES_W     = int'(bidir_shift_pkg::res_width(OP_W, AMT_W, AMT_SIGNED))
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             dir_i,
    output logic [RES_W-1:0] res_o
);
    logic [AMT_W-1:0] mag_d;
    logic             right_d;
    logic [RES_W-1:0] ext_d;
    logic             fill_d;
    logic [RES_W-1:0] shifted_d;

    shf_amt_decode #(
        .AMT_W      (AMT_W),
        .AMT_SIGNED (AMT_SIGNED)
    ) i_amt_decode (
        .amt_i   (amt_i),
        .dir_i   (dir_i),
        .mag_o   (mag_d),
        .right_o (right_d)
    );

    shf_extend #(
        .OP_W      (OP_W),
        .RES_W     (RES_W),
        .OP_SIGNED (OP_SIGNED)
    ) i_extend (
        .op_i   (op_i),
        .ext_o  (ext_d),
        .fill_o (fill_d)
    );

    shf_barrel #(
        .RES_W (RES_W),
        .MAG_W (AMT_W)
    ) i_barrel (
        .data_i  (ext_d),
        .mag_i   (mag_d),
        .right_i (right_d),
        .fill_i  (fill_d),
        .data_o  (shifted_d)
    );

    assign res_o = shifted_d;

endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
    parameter int OP_W       = 8,
    parameter int AMT_W      = 3,
    parameter bit OP_SIGNED  = 1'b0,
    parameter bit AMT_SIGNED = 1'b1,
    parameter int RES_W      = 8
) (
    input logic [OP_W-1:0]  op_i,
    input logic [AMT_W-1:0] amt_i,
    input logic             dir_i,
    input logic [RES_W-1:0] res_o
);
    logic             neg_c;
    logic [AMT_W-1:0] mag_c;
    logic [RES_W-1:0] low_mask_c;
    logic [RES_W-1:0] ext_c;

    always_comb begin
        neg_c      = AMT_SIGNED && amt_i[AMT_W-1];
        mag_c      = neg_c ? (AMT_W'(0) - amt_i) : amt_i;
        low_mask_c = (RES_W'(1) << mag_c) - RES_W'(1);
        ext_c      = {{(RES_W-OP_W){OP_SIGNED && op_i[OP_W-1]}}, op_i};

        if (amt_i == '0)
            assert_zero_amount_R7: assert (res_o == ext_c)
                else $error("zero amount changed operand");
        if (!dir_i && !neg_c)
            assert_left_low_zero_R1: assert ((res_o & low_mask_c) == '0)
                else $error("left shift low bits not zero");
        if (dir_i && neg_c)
            assert_rev_left_low_zero_R4: assert ((res_o & low_mask_c) == '0)
                else $error("reversed right shift low bits not zero");
        if (!OP_SIGNED && dir_i && !neg_c)
            assert_right_upper_zero_R2: assert ((res_o >> OP_W) == '0)
                else $error("unsigned right shift grew");
        if (!OP_SIGNED && !dir_i && neg_c)
            assert_rev_right_upper_zero_R3: assert ((res_o >> OP_W) == '0)
                else $error("reversed left shift grew");
        if (OP_SIGNED)
            assert_sign_kept_R6: assert (res_o[RES_W-1] == op_i[OP_W-1])
                else $error("sign not preserved");
    end

endmodule

bind bidir_shifter shf_checker #(
    .OP_W       (OP_W),
    .AMT_W      (AMT_W),
    .OP_SIGNED  (OP_SIGNED),
    .AMT_SIGNED (AMT_SIGNED),
    .RES_W      (RES_W)
) i_shf_checker (
    .op_i  (op_i),
    .amt_i (amt_i),
    .dir_i (dir_i),
    .res_o (res_o)
);

// File: tb/test_bidir_shifter.sv
module test_bidir_shifter;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Config A: unsigned 4-bit operand, signed 3-bit amount, 8-bit result
    logic [3:0]  op_a;
    logic [2:0]  amt_a;
    logic        dir_a;
    logic [7:0]  res_a;
    // Config B: unsigned 4-bit operand, unsigned 3-bit amount, 11-bit result
    logic [3:0]  op_b;
    logic [2:0]  amt_b;
    logic        dir_b;
    logic [10:0] res_b;
    // Config C: signed 5-bit operand, signed 3-bit amount, 9-bit result
    logic [4:0]  op_c;
    logic [2:0]  amt_c;
    logic        dir_c;
    logic [8:0]  res_c;

    bidir_shifter #(.OP_W(4), .AMT_W(3), .OP_SIGNED(1'b0), .AMT_SIGNED(1'b1)) i_bidir_shifter (
        .op_i(op_a), .amt_i(amt_a), .dir_i(dir_a), .res_o(res_a));
    bidir_shifter #(.OP_W(4), .AMT_W(3), .OP_SIGNED(1'b0), .AMT_SIGNED(1'b0)) i_bidir_shifter_uu (
        .op_i(op_b), .amt_i(amt_b), .dir_i(dir_b), .res_o(res_b));
    bidir_shifter #(.OP_W(5), .AMT_W(3), .OP_SIGNED(1'b1), .AMT_SIGNED(1'b1)) i_bidir_shifter_ss (
        .op_i(op_c), .amt_i(amt_c), .dir_i(dir_c), .res_o(res_c));

    task automatic check(input longint act, input longint exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic longint ref_shift(input longint v, input longint n, input bit right, input int w);
        longint r;
        longint m;
        bit     rt;
        m  = n;
        rt = right;
        if (m < 0) begin
            m  = -m;
            rt = !rt;
        end
        r = rt ? (v >>> m) : (v <<< m);
        return r & ((64'sd1 <<< w) - 1);
    endfunction

    function automatic string tag_of(input longint n, input bit right);
        if (n == 0) return "R7";
        if (n > 0)  return right ? "R2" : "R1";
        return right ? "R4" : "R3";
    endfunction

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        op_a = '0; amt_a = '0; dir_a = 1'b0;
        op_b = '0; amt_b = '0; dir_b = 1'b0;
        op_c = '0; amt_c = '0; dir_c = 1'b0;
        settle();

        // Reset-like idle state: zero inputs give zero results (R7)
        check(longint'(res_a), 0, "R7 idle A");
        check(longint'(res_b), 0, "R7 idle B");
        check(longint'(res_c), 0, "R7 idle C");

        // R5: result widths
        check($bits(i_bidir_shifter.res_o),    8,  "R5 width signed amount");
        check($bits(i_bidir_shifter_uu.res_o), 11, "R5 width unsigned amount");
        check($bits(i_bidir_shifter_ss.res_o), 9,  "R5 width signed operand");

        // R8: worked example on config A
        op_a = 4'b1001;
        amt_a = 3'd0; dir_a = 1'b0; settle(); check(longint'(res_a), 'b1001,    "R8 left 0");
        amt_a = 3'd3; dir_a = 1'b0; settle(); check(longint'(res_a), 'b1001000, "R8 left 3");
        amt_a = 3'b110; dir_a = 1'b0; settle(); check(longint'(res_a), 'b10,    "R8 left -2");
        amt_a = 3'd2; dir_a = 1'b1; settle(); check(longint'(res_a), 'b10,      "R8 right 2");
        amt_a = 3'b110; dir_a = 1'b1; settle(); check(longint'(res_a), 'b100100, "R8 right -2");

        // R9: extreme magnitudes
        op_a = 4'b1001; amt_a = 3'b100; dir_a = 1'b1; settle();
        check(longint'(res_a), 'h90, "R9 right by most negative");
        op_b = 4'b1111; amt_b = 3'd7; dir_b = 1'b0; settle();
        check(longint'(res_b), 'h780, "R9 left by max unsigned");
        op_c = 5'b10000; amt_c = 3'b100; dir_c = 1'b1; settle();
        check(longint'(res_c), 'h100, "R9 R6 signed reversed max");

        // Exhaustive sweep, config A
        for (int o = 0; o < 16; o++)
            for (int a = 0; a < 8; a++)
                for (int d = 0; d < 2; d++) begin
                    longint n;
                    op_a = 4'(o); amt_a = 3'(a); dir_a = d[0];
                    settle();
                    n = longint'($signed(amt_a));
                    check(longint'(res_a), ref_shift(longint'(o), n, d[0], 8), {tag_of(n, d[0]), " sweep A"});
                end

        // Exhaustive sweep, config B
        for (int o = 0; o < 16; o++)
            for (int a = 0; a < 8; a++)
                for (int d = 0; d < 2; d++) begin
                    op_b = 4'(o); amt_b = 3'(a); dir_b = d[0];
                    settle();
                    check(longint'(res_b), ref_shift(longint'(o), longint'(a), d[0], 11),
                          {tag_of(longint'(a), d[0]), " R6 sweep B"});
                end

        // Exhaustive sweep, config C (signed operand)
        for (int o = 0; o < 32; o++)
            for (int a = 0; a < 8; a++)
                for (int d = 0; d < 2; d++) begin
                    longint n;
                    longint v;
                    op_c = 5'(o); amt_c = 3'(a); dir_c = d[0];
                    settle();
                    n = longint'($signed(amt_c));
                    v = longint'($signed(op_c));
                    check(longint'(res_c), ref_shift(v, n, d[0], 9), {tag_of(n, d[0]), " R6 sweep C"});
                end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule